// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block maps a 16-bit virtual address onto a 15-bit physical address through a small page table held in flip-flops. The four upper address bits pick one of sixteen table entries. Each entry stores a 3-bit frame number and a present flag. The twelve lower bits go through unchanged as the offset within a 4096-byte page. Because there are only eight frames for sixteen pages, at most half of the virtual space can be resident at any time.

Software fills or clears entries through a single-entry write port. A requester presents an address with a one-cycle strobe. One clock later the block answers in one of two ways:
- a valid pulse carrying the physical address, or
- a fault pulse when the selected entry is marked absent. A fault carries no address.

Reset marks every entry absent, so every access faults until mappings are installed.

Top module: `vpage_xlate`

## Requirements
- R1: The page number is virtual address bits 15:12 and selects table entry 0 to 15 directly; bits 11:0 are the offset.
- R2: On a successful translation `rsp_paddr` equals {frame[2:0], offset[11:0]}, where the frame occupies bits 14:12.
- R3: Every cycle with `req_vld` high produces exactly one response cycle (either `rsp_vld` or `rsp_fault` high) on the next clock. No response appears without a request.
- R4: A request to an entry whose present flag is 0 raises `rsp_fault` with `rsp_paddr` = 0. `rsp_vld` and `rsp_fault` are never high together.
- R5: After reset every entry is absent, so a request to any of the 16 pages faults.
- R6: A table write (`tbl_we` high) updates the entry at the clock edge. A request in the same cycle sees the old entry, and a request one cycle later or after sees the new one.
- R7: Writing an entry with `tbl_present` = 0 unmaps it, and later requests to that page fault.
- R8: With page 5 mapped to frame 3, virtual address 20500 translates to physical address 12308.
- R9: With page 8 absent, virtual address 32780 faults.
- R10: A write changes only the entry named by `tbl_idx`.
- R11: `rsp_paddr` is 0 in every cycle where `rsp_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 4 | Entry (page number) to write |
| tbl_frame | input | 3 | Frame number to store |
| tbl_present | input | 1 | Present flag to store |
| req_vld | input | 1 | Translation request strobe |
| req_vaddr | input | 16 | Virtual address |
| rsp_vld | output | 1 | Translation succeeded, address valid |
| rsp_paddr | output | 15 | Physical address |
| rsp_fault | output | 1 | Page fault for the previous request |

## Verification
The bench targets the write/read collision on one entry. A design that forwarded the write data would return the new frame one cycle early, and a design that delayed the write would return the old frame one cycle late. It sweeps all sixteen pages, with some offsets at 0 and some at 4095, to catch a misplaced split between page and offset. It also checks the folding of sixteen pages onto eight frames. It unmaps entries and writes their neighbours, so a decoder that touched the wrong entry, or a fault path that leaked a stale address or also pulsed valid, would show at the outputs. Idle cycles are checked for spurious responses.

// File: rtl/vpx_pkg.sv
package vpx_pkg;
  localparam int unsigned VA_W    = 16;
  localparam int unsigned PAGE_W  = 4;
  localparam int unsigned FRAME_W = 3;

  typedef enum logic [1:0] {
    RSP_IDLE  = 2'd0,
    RSP_OK    = 2'd1,
    RSP_FAULT = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/vpx_table.sv
module vpx_table #(
  parameter int unsigned PAGE_W  = vpx_pkg::PAGE_W,
  parameter int unsigned FRAME_W = vpx_pkg::FRAME_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PAGE_W-1:0]  wr_idx,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic               wr_present,
  input  logic [PAGE_W-1:0]  rd_idx,
  output logic [FRAME_W-1:0] rd_frame,
  output logic               rd_present
);
  localparam int unsigned ENTRIES = 1 << PAGE_W;

  logic [FRAME_W-1:0] frame_q [ENTRIES];
  logic [ENTRIES-1:0] pres_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic               ent_en;
    logic [FRAME_W-1:0] frame_d;
    logic               pres_d;

    always_comb begin
      ent_en  = wr_en && (wr_idx == PAGE_W'(g));
      frame_d = frame_q[g];
      pres_d  = pres_q[g];
      if (ent_en) begin
        frame_d = wr_frame;
        pres_d  = wr_present;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        frame_q[g] <= '0;
        pres_q[g]  <= 1'b0;
      end else begin
        frame_q[g] <= frame_d;
        pres_q[g]  <= pres_d;
      end
    end
  end

  assign rd_frame   = frame_q[rd_idx];
  assign rd_present = pres_q[rd_idx];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pres_q[$past(wr_idx)] == $past(wr_present))
           && (frame_q[$past(wr_idx)] == $past(wr_frame))); // R6
  AST_WRITE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != rd_idx) |=> $stable(pres_q[$past(rd_idx)])); // R10
endmodule

// File: rtl/vpx_lookup.sv
module vpx_lookup #(
  parameter int unsigned VA_W    = vpx_pkg::VA_W,
  parameter int unsigned PAGE_W  = vpx_pkg::PAGE_W,
  parameter int unsigned FRAME_W = vpx_pkg::FRAME_W
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_vld,
  input  logic [VA_W-1:0]                     req_vaddr,
  output logic [PAGE_W-1:0]                   page_idx,
  input  logic [FRAME_W-1:0]                  ent_frame,
  input  logic                                ent_present,
  output logic                                rsp_vld,
  output logic                                rsp_fault,
  output logic [FRAME_W+VA_W-PAGE_W-1:0]      rsp_paddr
);
  import vpx_pkg::*;
  localparam int unsigned OFF_W = VA_W - PAGE_W;
  localparam int unsigned PA_W  = FRAME_W + OFF_W;

  rsp_kind_e         kind_d, kind_q;
  logic [PA_W-1:0]   paddr_d, paddr_q;

  assign page_idx = req_vaddr[VA_W-1:OFF_W];

  always_comb begin
    kind_d  = RSP_IDLE;
    paddr_d = '0;
    if (req_vld) begin
      if (ent_present) begin
        kind_d  = RSP_OK;
        paddr_d = {ent_frame, req_vaddr[OFF_W-1:0]};
      end else begin
        kind_d  = RSP_FAULT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= RSP_IDLE;
      paddr_q <= '0;
    end else begin
      kind_q  <= kind_d;
      paddr_q <= paddr_d;
    end
  end

  assign rsp_vld   = (kind_q == RSP_OK);
  assign rsp_fault = (kind_q == RSP_FAULT);
  assign rsp_paddr = paddr_q;

  AST_ONE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (rsp_vld || rsp_fault)); // R3
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !(rsp_vld || rsp_fault)); // R3
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_vld && rsp_fault)); // R4
  AST_FAULT_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !ent_present) |=> rsp_fault); // R4
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])); // R2
  AST_QUIET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld |-> rsp_paddr == '0); // R11
endmodule

// File: rtl/vpage_xlate.sv
module vpage_xlate #(
  parameter int unsigned VA_W    = vpx_pkg::VA_W,
  parameter int unsigned PAGE_W  = vpx_pkg::PAGE_W,
  parameter int unsigned FRAME_W = vpx_pkg::FRAME_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           tbl_we,
  input  logic [PAGE_W-1:0]              tbl_idx,
  input  logic [FRAME_W-1:0]             tbl_frame,
  input  logic                           tbl_present,
  input  logic                           req_vld,
  input  logic [VA_W-1:0]                req_vaddr,
  output logic                           rsp_vld,
  output logic [FRAME_W+VA_W-PAGE_W-1:0] rsp_paddr,
  output logic                           rsp_fault
);
  logic [PAGE_W-1:0]  lk_idx;
  logic [FRAME_W-1:0] lk_frame;
  logic               lk_present;

  vpx_table #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (tbl_we),
    .wr_idx     (tbl_idx),
    .wr_frame   (tbl_frame),
    .wr_present (tbl_present),
    .rd_idx     (lk_idx),
    .rd_frame   (lk_frame),
    .rd_present (lk_present)
  );

  vpx_lookup #(.VA_W(VA_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_lookup (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_vld     (req_vld),
    .req_vaddr   (req_vaddr),
    .page_idx    (lk_idx),
    .ent_frame   (lk_frame),
    .ent_present (lk_present),
    .rsp_vld     (rsp_vld),
    .rsp_fault   (rsp_fault),
    .rsp_paddr   (rsp_paddr)
  );
endmodule

// File: tb/test_vpage_xlate.sv
module test_vpage_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_idx = '0;
  logic [2:0]  tbl_frame = '0;
  logic        tbl_present = 1'b0;
  logic        req_vld = 1'b0;
  logic [15:0] req_vaddr = '0;
  logic        rsp_vld;
  logic [14:0] rsp_paddr;
  logic        rsp_fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpage_xlate i_vpage_xlate (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_frame(tbl_frame), .tbl_present(tbl_present), .req_vld(req_vld),
    .req_vaddr(req_vaddr), .rsp_vld(rsp_vld), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault)
  );

  task automatic chk(string tag, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // outputs packed as {vld, fault, paddr}
  function automatic logic [16:0] ok(logic [14:0] pa);
    return {1'b1, 1'b0, pa};
  endfunction
  localparam logic [16:0] FAULT = {1'b0, 1'b1, 15'd0};
  localparam logic [16:0] IDLE  = 17'd0;

  task automatic wr(logic [3:0] idx, logic [2:0] fr, logic pr);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = idx; tbl_frame = fr; tbl_present = pr;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic xl(string tag, logic [15:0] va, logic [16:0] exp);
    @(negedge clk);
    req_vld = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_vld = 1'b0;
    chk(tag, {rsp_vld, rsp_fault, rsp_paddr}, exp);
  endtask

  task automatic t_reset();
    chk("R5 reset outputs", {rsp_vld, rsp_fault, rsp_paddr}, IDLE);
    for (int p = 0; p < 16; p++) xl("R5 all absent after reset", {p[3:0], 12'h5a5}, FAULT);
  endtask

  task automatic t_examples();
    wr(4'd5, 3'd3, 1'b1);
    xl("R8 20500 to 12308", 16'd20500, ok(15'd12308));
    xl("R9 32780 faults", 16'd32780, FAULT);
  endtask

  task automatic t_sweep();
    for (int p = 0; p < 16; p++) wr(p[3:0], 3'(7 - (p % 8)), 1'b1);
    for (int p = 0; p < 16; p++) begin
      logic [11:0] off;
      off = (p % 2 == 0) ? 12'hfff : 12'h000;
      xl("R1 R2 sweep", {p[3:0], off}, ok({3'(7 - (p % 8)), off}));
    end
  endtask

  task automatic t_idle();
    @(negedge clk);
    @(negedge clk);
    chk("R3 R11 idle no response", {rsp_vld, rsp_fault, rsp_paddr}, IDLE);
  endtask

  task automatic t_collision();
    wr(4'd2, 3'd1, 1'b1);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 4'd2; tbl_frame = 3'd6; tbl_present = 1'b1;
    req_vld = 1'b1; req_vaddr = 16'h2abc;
    @(negedge clk);
    tbl_we = 1'b0;
    chk("R6 same cycle sees old", {rsp_vld, rsp_fault, rsp_paddr}, ok({3'd1, 12'habc}));
    req_vaddr = 16'h2abd;
    @(negedge clk);
    req_vld = 1'b0;
    chk("R6 next cycle sees new", {rsp_vld, rsp_fault, rsp_paddr}, ok({3'd6, 12'habd}));
    @(negedge clk);
    chk("R3 single pulse", {rsp_vld, rsp_fault, rsp_paddr}, IDLE);
  endtask

  task automatic t_unmap();
    wr(4'd9, 3'd4, 1'b1);
    wr(4'd10, 3'd5, 1'b1);
    wr(4'd9, 3'd4, 1'b0);
    xl("R7 unmapped faults", 16'h9123, FAULT);
    xl("R10 neighbour kept", 16'ha123, ok({3'd5, 12'h123}));
    xl("R10 lower neighbour kept", 16'h8001, ok({3'd7, 12'h001}));
    xl("R4 fault then ok", 16'h9fff, FAULT);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_examples();
    t_idle();
    t_sweep();
    t_collision();
    t_unmap();
    t_idle();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule